// File: doc/BRIEF.md
# Three-Phase No-Load Creep Detector

This block keeps an energy meter from creeping when line voltage is present but no meaningful current flows. Each of the three phases has two stall timers. One counts sample-rate ticks since the phase's active-energy accumulator last received a least-significant-bit increment. The other does the same for the apparent-energy accumulator. Two shared 16-bit timeout values set the limits. A limit of zero removes that criterion. With both limits at zero, detection is off.

When every enabled criterion of a phase has stalled, the phase enters no-load. While it is in no-load, its accumulate-enable gate is held low, and the surrounding energy datapath uses that gate to stop accumulating active energy and to stop making active-energy pulses for that phase. A fresh increment on any enabled criterion takes the phase back out.

Each entry into or exit from no-load, on any phase, sets a sticky status bit. A small register port lets software read the status bit, read and write an interrupt mask bit, and read the per-phase state field. Software clears the status bit by writing 1 to it. The active-low interrupt pin is asserted while the status bit and the mask bit are both set.

Top module: `nl_detect`

## Requirements
- R1: Each stall timer loads 0 on an increment strobe of its energy type, otherwise adds 1 on each tick until it equals its limit, then holds. A phase enters no-load at the clock edge where its enabled timers reach their limits.
- R2: A strobe on an enabled criterion of a phase in no-load takes that phase out of no-load at the next clock edge. Its timer restarts from 0, so re-entry takes a full timeout.
- R3: `act_acc_en[p]` is low while phase p is in no-load. The one exception is a cycle in which phase p has a strobe on an enabled criterion: the gate is then high in that same cycle. Outside no-load the gate is high.
- R4: When both limits are zero, every phase leaves or stays out of no-load at the next edge.
- R5: With only the apparent limit zero, apparent strobes are ignored and no-load follows the active timer alone. With only the active limit zero, active strobes are ignored and no-load follows the apparent timer alone.
- R6: Register address 2 reads the phase state in bits [2:0], with bit p set when phase p (0=A, 1=B, 2=C) is in no-load. The field changes at the same edge as the status bit.
- R7: The status bit (address 0, bit 0) becomes 1 at the edge where any phase enters or leaves no-load.
- R8: The mask bit (address 1, bit 0) is read/write. `irq_n` is low exactly while status and mask are both 1.
- R9: Writing 1 to address 0 bit 0 clears the status bit. Writing 0 leaves it unchanged.
- R10: A status-clear write in the same cycle as an entry or exit event leaves the status bit at 1.
- R11: After reset the state field, status and mask are 0, `irq_n` is 1, all timers are 0 and all gates are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate tick, one cycle wide |
| act_inc | input | 3 | Per-phase active-energy LSB increment strobe |
| app_inc | input | 3 | Per-phase apparent-energy LSB increment strobe |
| act_limit | input | 16 | Active-energy stall timeout in ticks, 0 removes the criterion |
| app_limit | input | 16 | Apparent-energy stall timeout in ticks, 0 removes the criterion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 mask, 2 phase state) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, follows reg_addr combinationally |
| phase_state | output | 3 | Per-phase no-load state |
| status | output | 1 | Sticky no-load change status |
| irq_n | output | 1 | Active-low interrupt |
| act_acc_en | output | 3 | Per-phase active accumulation and pulse enable |

## Verification
The bench exercises entry at exactly the tick where a timer meets its limit. A design that compares with greater-than would enter one tick late. After a long stall it checks that one strobe restarts the full timeout. A design whose timers keep counting past the limit, or that only clears a flag, would re-enter early or never leave. It drives strobes of a zero-limit criterion in each single-criterion mode, and lowers both limits to zero while phases are in no-load. A design that lets a disabled criterion count would fail to enter, or would wrongly exit. Finally, it lines up a status-clear write with an exit event, and checks that the accumulate gate rises in the same cycle as the exiting strobe. A design with the wrong clear priority would lose the event, and one with the wrong gate timing would drop the first increment.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_PHASE  = 2'd2;

  typedef struct packed {
    logic act_stall;
    logic app_stall;
  } stall_pair_t;
endpackage

// File: rtl/nl_stall_timer.sv
module nl_stall_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          strobe,
  input  logic [TW-1:0] limit,
  output logic          stall_nx
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = strobe | (tick & (cnt_q < limit));
    if (strobe) cnt_d = '0;
    else if (tick && (cnt_q < limit)) cnt_d = cnt_q + 1'b1;
    else cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Stall is judged on the value that is about to be loaded.
  assign stall_nx = (cnt_d >= limit);

  assert_reload_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (cnt_q == '0));
  assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !strobe) |=> $stable(cnt_q));
endmodule

// File: rtl/nl_phase.sv
module nl_phase
  import nl_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          act_inc,
  input  logic          app_inc,
  input  logic [TW-1:0] act_limit,
  input  logic [TW-1:0] app_limit,
  output logic          nl_q,
  output logic          flip,
  output logic          acc_en
);
  stall_pair_t st;
  logic act_on, app_on, hit, nl_d;

  nl_stall_timer #(.TW(TW)) u_act_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(act_inc),
    .limit(act_limit), .stall_nx(st.act_stall)
  );

  nl_stall_timer #(.TW(TW)) u_app_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(app_inc),
    .limit(app_limit), .stall_nx(st.app_stall)
  );

  always_comb begin
    act_on = |act_limit;
    app_on = |app_limit;
    hit    = (act_on & act_inc) | (app_on & app_inc);
    nl_d   = (act_on | app_on)
           & (~act_on | st.act_stall)
           & (~app_on | st.app_stall);
    flip   = nl_d ^ nl_q;
    acc_en = ~nl_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nl_q <= 1'b0;
    else        nl_q <= nl_d;
  end

  assert_strobe_exits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_q && hit) |=> !nl_q);
  assert_gate_low_in_noload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_q && !act_inc && !app_inc) |-> !acc_en);
  assert_both_zero_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_limit == '0 && app_limit == '0) |=> !nl_q);
endmodule

// File: rtl/nl_irq_regs.sv
module nl_irq_regs
  import nl_pkg::*;
#(
  parameter int unsigned NPH = 3,
  parameter int unsigned DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_any,
  input  logic [NPH-1:0]    ph_state,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              status,
  output logic              irq_n
);
  logic sts_q, sts_d, msk_q, msk_d, clr_wr, msk_wr;

  always_comb begin
    clr_wr = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[0];
    msk_wr = reg_wr && (reg_addr == ADDR_MASK);
    // New events win over a coincident clear.
    sts_d  = event_any | (sts_q & ~clr_wr);
    msk_d  = msk_wr ? reg_wdata[0] : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      msk_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      if (msk_wr) msk_q <= msk_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STATUS: reg_rdata[0] = sts_q;
      ADDR_MASK:   reg_rdata[0] = msk_q;
      ADDR_PHASE:  reg_rdata[NPH-1:0] = ph_state;
      default:     reg_rdata = '0;
    endcase
  end

  assign status = sts_q;
  assign irq_n  = ~(sts_q & msk_q);

  assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    event_any |=> sts_q);
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !event_any) |=> !sts_q);
  assert_mask_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_wr |=> $stable(msk_q));
endmodule

// File: rtl/nl_detect.sv
module nl_detect
  import nl_pkg::*;
#(
  parameter int unsigned NPH = 3,
  parameter int unsigned TW  = 16,
  parameter int unsigned DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NPH-1:0]    act_inc,
  input  logic [NPH-1:0]    app_inc,
  input  logic [TW-1:0]     act_limit,
  input  logic [TW-1:0]     app_limit,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NPH-1:0]    phase_state,
  output logic              status,
  output logic              irq_n,
  output logic [NPH-1:0]    act_acc_en
);
  logic [NPH-1:0] flips;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    nl_phase #(.TW(TW)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .act_inc(act_inc[p]), .app_inc(app_inc[p]),
      .act_limit(act_limit), .app_limit(app_limit),
      .nl_q(phase_state[p]), .flip(flips[p]), .acc_en(act_acc_en[p])
    );
  end

  nl_irq_regs #(.NPH(NPH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .event_any(|flips), .ph_state(phase_state),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status(status), .irq_n(irq_n)
  );

  assert_state_change_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_state != $past(phase_state)) |-> status);
endmodule

// File: tb/nl_detect_tb.sv
module nl_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [2:0]  act_inc, app_inc;
  logic [15:0] act_limit, app_limit;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [2:0]  phase_state, act_acc_en;
  logic        status, irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  nl_detect u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act_inc(act_inc), .app_inc(app_inc),
    .act_limit(act_limit), .app_limit(app_limit), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .phase_state(phase_state), .status(status), .irq_n(irq_n),
    .act_acc_en(act_acc_en)
  );

  // {act_inc, app_inc, tick, expected phase_state}; limits 2 and 2
  localparam logic [9:0] VEC [10] = '{
    {3'b000, 3'b000, 1'b1, 3'b000},
    {3'b010, 3'b000, 1'b1, 3'b101},
    {3'b000, 3'b010, 1'b1, 3'b101},
    {3'b000, 3'b000, 1'b1, 3'b101},
    {3'b000, 3'b000, 1'b1, 3'b111},
    {3'b001, 3'b000, 1'b0, 3'b110},
    {3'b000, 3'b000, 1'b0, 3'b110},
    {3'b000, 3'b100, 1'b1, 3'b010},
    {3'b000, 3'b000, 1'b1, 3'b011},
    {3'b000, 3'b000, 1'b1, 3'b111}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic [2:0] b, input logic t,
                     input logic w, input logic [1:0] ad, input logic [7:0] wd);
    @(negedge clk);
    act_inc = a; app_inc = b; tick = t;
    reg_wr = w; reg_addr = ad; reg_wdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    act_inc = '0; app_inc = '0; tick = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    act_limit = 16'd2; app_limit = 16'd2;
    do_reset();
    #1;
    chk("R11 state", {5'b0, phase_state}, 8'h00);
    chk("R11 status", {7'b0, status}, 8'h00);
    chk("R11 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R11 gates", {5'b0, act_acc_en}, 8'h07);
    reg_addr = 2'd1; #1;
    chk("R11 mask read", reg_rdata, 8'h00);

    // Vector walk: R1 entry timing, R2 exits, R3 gates
    for (int i = 0; i < 10; i++) begin
      cyc(VEC[i][9:7], VEC[i][6:4], VEC[i][3], 1'b0, 2'd0, 8'h00);
      chk($sformatf("R1 R2 vec%0d state", i), {5'b0, phase_state}, {5'b0, VEC[i][2:0]});
      chk($sformatf("R3 vec%0d gate", i), {5'b0, act_acc_en}, {5'b0, ~VEC[i][2:0]});
    end

    cyc(3'b0, 3'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    chk("R7 status read", reg_rdata, 8'h01);
    chk("R8 irq masked", {7'b0, irq_n}, 8'h01);
    cyc(3'b0, 3'b0, 1'b0, 1'b1, 2'd0, 8'h00);
    chk("R9 write0 keeps", {7'b0, status}, 8'h01);
    cyc(3'b0, 3'b0, 1'b0, 1'b1, 2'd1, 8'h01);
    chk("R8 irq asserted", {7'b0, irq_n}, 8'h00);
    chk("R8 mask read", reg_rdata, 8'h01);
    cyc(3'b0, 3'b0, 1'b0, 1'b1, 2'd0, 8'h01);
    chk("R9 clear", {7'b0, status}, 8'h00);
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);
    // Clear write coincides with phase A exit
    cyc(3'b001, 3'b0, 1'b0, 1'b1, 2'd0, 8'h01);
    chk("R10 status kept", {7'b0, status}, 8'h01);
    chk("R10 state", {5'b0, phase_state}, 8'h06);

    // Gate rises in the strobe's own cycle
    @(negedge clk);
    reg_wr = 1'b0; act_inc = 3'b010; reg_addr = 2'd2;
    #1;
    chk("R3 same-cycle gate", {7'b0, act_acc_en[1]}, 8'h01);
    chk("R3 still in noload", {5'b0, phase_state}, 8'h06);
    @(posedge clk); #1;
    chk("R2 exit next edge", {5'b0, phase_state}, 8'h04);
    chk("R6 state read", reg_rdata, 8'h04);

    // Saturation then single strobe: full timeout needed again
    act_limit = 16'd3; app_limit = 16'd3;
    do_reset();
    for (int i = 0; i < 100; i++) cyc(3'b0, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R1 saturated entry", {5'b0, phase_state}, 8'h07);
    cyc(3'b001, 3'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    chk("R2 exit after long stall", {5'b0, phase_state}, 8'h06);
    cyc(3'b0, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R2 no early reentry 1", {5'b0, phase_state}, 8'h06);
    cyc(3'b0, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R2 no early reentry 2", {5'b0, phase_state}, 8'h06);
    cyc(3'b0, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R1 reentry at limit", {5'b0, phase_state}, 8'h07);

    // Apparent-only mode: active strobes ignored
    act_limit = 16'd0; app_limit = 16'd2;
    do_reset();
    cyc(3'b111, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    cyc(3'b111, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R5 app-only entry", {5'b0, phase_state}, 8'h07);
    cyc(3'b111, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R5 act strobe ignored", {5'b0, phase_state}, 8'h07);
    chk("R3 gate stays low", {5'b0, act_acc_en}, 8'h00);

    // Active-only mode: apparent strobes ignored
    act_limit = 16'd2; app_limit = 16'd0;
    do_reset();
    cyc(3'b0, 3'b111, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R5 act-only before limit", {5'b0, phase_state}, 8'h00);
    cyc(3'b0, 3'b111, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R5 act-only entry", {5'b0, phase_state}, 8'h07);
    cyc(3'b0, 3'b0, 1'b1, 1'b1, 2'd0, 8'h01);
    chk("R9 cleared before disable", {7'b0, status}, 8'h00);

    // Both limits zero while in no-load: forced exit
    @(negedge clk);
    reg_wr = 1'b0; act_limit = 16'd0;
    @(posedge clk); #1;
    chk("R4 disable exits", {5'b0, phase_state}, 8'h00);
    chk("R7 exit sets status", {7'b0, status}, 8'h01);
    do_reset();
    for (int i = 0; i < 50; i++) cyc(3'b0, 3'b0, 1'b1, 1'b0, 2'd0, 8'h00);
    chk("R4 never enters", {5'b0, phase_state}, 8'h00);
    chk("R4 no status", {7'b0, status}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule